// File: doc/BRIEF.md
# Bus Capture Scope Overlay

This block is an on-chip logic analyser for a bus interface. A one-cycle pulse on `arm` starts an acquisition. From the next clock edge on, the block stores one word holding all probe bits on each clock. After 640 words it stops. The stored window then stays unchanged until the next arm pulse. At a 100 MHz sample clock, the window covers 6.4 µs at 10 ns per sample.

The same memory is read by the video raster. Each screen column shows one sample. Each signal owns a band of eight scan lines, and the bands run down the screen. The host side of the chip supplies the video counters and the display-enable. The block returns a pixel colour and a flag that marks where the overlay covers the picture. The first five bands show the bus control strobes and the bus clock. The following 23 bands show the address lines, highest first.

Top module: `bus_scope`

## Requirements
- R1: After an arm pulse is seen at a clock edge, the probe word present at the n-th following edge (n = 1..640) becomes sample n-1, and screen column c shows sample c.
- R2: Once sample 639 is stored, writing stops. Later probe activity leaves every column unchanged until the next arm pulse.
- R3: An arm pulse always restarts capture at sample 0, and the new acquisition replaces the previous window.
- R4: Band b covers lines 8b to 8b+7 and shows probe bit b. The bit order is: bit 0 = data output enable, bit 1 = read, bit 2 = upper data strobe, bit 3 = address strobe, bit 4 = bus clock, and bits 5..27 = address lines 23 down to 1.
- R5: Lines 0..6 of a band are drawn in 24'h00FF00 when the sampled bit is 1 and in 24'h003000 when it is 0. Line 7 of every band is black (24'h000000).
- R6: `overlay` is 1 exactly when `de` is 1, `hpos` < 640 and `vpos` < 224. `overlay` and `rgb` reflect the inputs sampled at the preceding clock edge.
- R7: While `overlay` is 0, `rgb` is 24'h000000.
- R8: If the raster reads a column in the same cycle that capture writes that column, the pixel shows the previously stored sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new acquisition |
| probe | input | 28 | Probe signals, bit order per R4 |
| hpos | input | 11 | Raster column |
| vpos | input | 11 | Raster line |
| de | input | 1 | Display enable |
| rgb | output | 24 | Pixel colour |
| overlay | output | 1 | Overlay covers this pixel |

## Verification
Capture writes and raster reads share the memory, so both can address the same column in one cycle. The bench provokes this during a second acquisition. It drives the raster to the column that is being written at that edge. The pixel must show the sample from the earlier acquisition (R8). A later readback of the same column must show the new sample.

// File: rtl/bus_scope.sv
module bus_scope #(
  parameter int NPROBE = 28,
  parameter int DEPTH  = 640,
  parameter int BAND   = 8,
  parameter int X_W    = 11,
  parameter int Y_W    = 11,
  parameter logic [23:0] HI_RGB = 24'h00FF00,
  parameter logic [23:0] LO_RGB = 24'h003000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [NPROBE-1:0] probe,
  input  logic [X_W-1:0]    hpos,
  input  logic [Y_W-1:0]    vpos,
  input  logic              de,
  output logic [23:0]       rgb,
  output logic              overlay
);
  localparam int A_W = $clog2(DEPTH);
  localparam int B_W = $clog2(BAND);
  localparam int R_W = $clog2(NPROBE);
  localparam logic [X_W-1:0] COLS_L = X_W'(DEPTH);
  localparam logic [Y_W-1:0] ROWS_L = Y_W'(NPROBE * BAND);
  localparam logic [A_W-1:0] LAST_L = A_W'(DEPTH - 1);
  localparam logic [R_W-1:0] NP_L   = R_W'(NPROBE);

  logic [NPROBE-1:0] mem [DEPTH];
  logic              capturing;
  logic [A_W-1:0]    wr_ptr;
  logic [NPROBE-1:0] rd_q;
  logic [R_W-1:0]    band_q;
  logic              gap_q, ovl_q;

  wire in_cols = hpos < COLS_L;
  wire in_rows = vpos < ROWS_L;
  wire [A_W-1:0] rd_addr = in_cols ? hpos[A_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capturing <= 1'b0;
      wr_ptr    <= '0;
    end else if (arm) begin
      capturing <= 1'b1;
      wr_ptr    <= '0;
    end else if (capturing) begin
      if (wr_ptr == LAST_L) capturing <= 1'b0;
      else                  wr_ptr    <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (capturing && !arm) mem[wr_ptr] <= probe;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_q  <= 1'b0;
      band_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      ovl_q  <= de && in_cols && in_rows;
      band_q <= vpos[B_W +: R_W];
      gap_q  <= &vpos[B_W-1:0];
    end
  end

  wire bit_on = (band_q < NP_L) ? rd_q[band_q] : 1'b0;

  assign overlay = ovl_q;
  assign rgb = (!ovl_q || gap_q) ? 24'h0 : (bit_on ? HI_RGB : LO_RGB);

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= LAST_L); // R1
  AST_CAP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    capturing && wr_ptr == LAST_L && !arm |=> !capturing); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !capturing && !arm |=> !capturing && $stable(wr_ptr)); // R2
  AST_ARM_START: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> capturing && wr_ptr == '0); // R3
  AST_OVL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !de || !in_cols || !in_rows |=> !overlay); // R6
  AST_BLACK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay |-> rgb == 24'h0); // R7
endmodule

// File: tb/bus_scope_bench.sv
module bus_scope_bench;
  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, de = 1'b0;
  logic [27:0] probe = '0;
  logic [10:0] hpos = '0, vpos = '0;
  logic [23:0] rgb;
  logic overlay;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  bus_scope u_bus_scope (.clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe),
    .hpos(hpos), .vpos(vpos), .de(de), .rgb(rgb), .overlay(overlay));

  function automatic logic [27:0] pat(int s, int i);
    logic [31:0] v;
    v = (i * 32'h9E3779B1) ^ (s * 32'h0001F3A7) ^ (i << 7) ^ (i >> 2);
    return v[27:0];
  endfunction

  function automatic logic [24:0] expect_px(logic [27:0] w, int x, int y, logic en);
    logic ov;
    ov = en && x < 640 && y < 224;
    if (!ov) return 25'h0;
    if (y % 8 == 7) return {1'b1, 24'h0};
    return {1'b1, w[y / 8] ? 24'h00FF00 : 24'h003000};
  endfunction

  task automatic chk(string tag, logic [24:0] act, logic [24:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(int x, int y, logic en, output logic [24:0] got);
    @(negedge clk); hpos = 11'(x); vpos = 11'(y); de = en;
    @(negedge clk); got = {overlay, rgb};
    de = 1'b0;
  endtask

  task automatic acquire(int s, int prev, int coll, int crow);
    logic [24:0] got;
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    for (int i = 0; i < 640; i++) begin
      if (coll >= 0 && i == coll + 1) begin
        got = {overlay, rgb};
        chk("R8 collide old sample", got, expect_px(pat(prev, coll), coll, crow, 1'b1));
        de = 1'b0;
      end
      probe = pat(s, i);
      if (i == coll) begin hpos = 11'(coll); vpos = 11'(crow); de = 1'b1; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [24:0] got;
    look(10, 10, 1'b0, got);
    chk("R7 reset no overlay", got, 25'h0);
  endtask

  task automatic t_first;
    logic [24:0] got;
    acquire(1, 0, -1, 0);
    for (int k = 0; k < 400; k++) begin
      probe = ~pat(1, k);
      @(negedge clk);
    end
    for (int c = 0; c < 640; c += 13) begin
      look(c, (c % 28) * 8 + (c % 7), 1'b1, got);
      chk("R1 R2 column sample", got, expect_px(pat(1, c), c, (c % 28) * 8 + (c % 7), 1'b1));
    end
    look(639, 0, 1'b1, got);
    chk("R1 last column", got, expect_px(pat(1, 639), 639, 0, 1'b1));
    for (int y = 0; y < 40; y++) begin
      look(0, y, 1'b1, got);
      chk("R4 R5 control bands", got, expect_px(pat(1, 0), 0, y, 1'b1));
    end
    look(5, 223, 1'b1, got);
    chk("R5 gap last band", got, {1'b1, 24'h0});
    look(5, 216, 1'b1, got);
    chk("R4 address line 1 band", got, expect_px(pat(1, 5), 5, 216, 1'b1));
  endtask

  task automatic t_edges;
    logic [24:0] got;
    look(640, 0, 1'b1, got);
    chk("R6 column 640 outside", got, 25'h0);
    look(100, 224, 1'b1, got);
    chk("R6 line 224 outside", got, 25'h0);
    look(100, 8, 1'b0, got);
    chk("R7 de low black", got, 25'h0);
    look(2000, 2000, 1'b1, got);
    chk("R7 far outside", got, 25'h0);
  endtask

  task automatic t_rearm;
    logic [24:0] got;
    acquire(2, 1, 300, 41);
    for (int c = 1; c < 640; c += 29) begin
      look(c, (c % 28) * 8 + 2, 1'b1, got);
      chk("R3 rearm new window", got, expect_px(pat(2, c), c, (c % 28) * 8 + 2, 1'b1));
    end
    look(300, 41, 1'b1, got);
    chk("R8 collide then new", got, expect_px(pat(2, 300), 300, 41, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first();
    t_edges();
    t_rearm();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule